// File: doc/BRIEF.md
# SPI Master Register and Interrupt File

This block is the bus-facing half of a byte-oriented SPI master. A plain 32-bit register bus sees a configuration word, a controller enable, a delay word, an idle-count field and a TX watermark. A write port feeds bytes into a transmit FIFO, and a read port pops bytes from a receive FIFO. Both FIFOs sit inside the block. The serial shift engine is a separate block. It takes transmit bytes through a valid/pop handshake, delivers receive bytes through a push strobe, and reports a mode fault as a one-cycle pulse.

Seven interrupt sources share one bit layout across the status, enable, disable and mask registers. Event sources latch until software clears them by writing ones. Level sources mirror the FIFO state directly. Software changes the mask only through write-only set and clear registers, and reads it back separately. A single interrupt line is the OR of every status bit that is also set in the mask.

Top module: `spi_regfile`

## Requirements
- R1: After synchronous reset the register values are: configuration 0, enable 0, delay 0, idle count 0, TX watermark 1, mask 0 and status 0. After reset `irq` and `eng_tx_valid` are 0.
- R2: The read/write registers are configuration at 0x00 (32 bits), enable at 0x14 (bit 0 only), delay at 0x18 (32 bits), idle count at 0x24 (low 8 bits) and TX watermark at 0x28 (low 8 bits). Bits outside those widths read 0. The configuration, enable, delay and idle-count values also appear on output ports.
- R3: Writing ones to the set register (0x08) sets the matching mask bits. Writing ones to the clear register (0x0C) clears them. Zero bits in either write leave the mask unchanged. The mask reads at 0x10 and has 7 bits. Registers 0x08 and 0x0C read 0.
- R4: Status reads at 0x04. Bit 0 is RX overrun, bit 1 is mode fault, bit 2 is TX low and bit 6 is TX underrun. These event bits latch one cycle after their cause and stay set until a write to 0x04 carries a 1 in that position. If an event arrives in the same cycle as its clear, the event wins.
- R5: Status bits 3 (TX full), 4 (RX not empty) and 5 (RX full) follow the FIFO state. Writes to 0x04 do not change them.
- R6: A write to 0x1C pushes bits 7:0 into the 128-entry TX FIFO. The engine sees the bytes in write order on `eng_tx_data` while `eng_tx_valid` is high, and `eng_tx_pop` removes one byte. A write when the FIFO is full is dropped.
- R7: `eng_rx_push` stores `eng_rx_data` in the 128-entry RX FIFO. A read of 0x20 returns the oldest byte, zero-extended, and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R8: The TX-low event (bit 2) latches when the TX fill count goes from at least the watermark to below it. Being below the watermark at reset does not raise it.
- R9: A one-cycle pulse on `eng_mode_fault` latches status bit 1.
- R10: An engine push into a full RX FIFO discards the byte and latches bit 0. An engine pop from an empty TX FIFO latches bit 6.
- R11: `irq` is high exactly when some status bit is set and its mask bit is also set.
- R12: Unmapped addresses and the write-only TX data register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe; pops RX when addressing 0x20 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| eng_tx_data | output | 8 | Oldest TX byte |
| eng_tx_valid | output | 1 | TX FIFO holds at least one byte |
| eng_tx_pop | input | 1 | Engine takes one TX byte |
| eng_rx_push | input | 1 | Engine delivers one RX byte |
| eng_rx_data | input | 8 | Received byte |
| eng_mode_fault | input | 1 | Mode fault pulse from the engine |
| cfg_word | output | 32 | Configuration register |
| ctl_enable | output | 1 | Controller enable |
| delay_word | output | 32 | Delay register |
| idle_count | output | 8 | Idle-count field |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that engine strobes and bus strobes are single-cycle pulses with known values once reset is released. They also assume that at most one bus access is presented per cycle, so the mask set and clear registers are never written together. The stimulus drives every input on the falling clock edge and issues one access at a time. The only exception is a deliberate pairing of a mode-fault pulse with a status clear, which probes the set-over-clear priority. FIFO fills and drains run the full 128 entries plus one, so both the full boundary and the empty boundary are crossed in each direction.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int IRQ_W  = 7;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MSET   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MCLR   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_EN     = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_DELAY  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_TXD    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_RXD    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_IDLE   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_WMARK  = 8'h28;

    // Interrupt vector, MSB first: bit 6 down to bit 0
    typedef struct packed {
        logic tx_under;    // 6 event
        logic rx_full;     // 5 level
        logic rx_avail;    // 4 level
        logic tx_full;     // 3 level
        logic tx_low;      // 2 event
        logic mode_fault;  // 1 event
        logic rx_ovr;      // 0 event
    } irq_vec_t;

    localparam logic [IRQ_W-1:0] EVENT_BITS = 7'b100_0111;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CFG, SEL_STATUS, SEL_MSET, SEL_MCLR, SEL_MASK,
        SEL_EN, SEL_DELAY, SEL_TXD, SEL_RXD, SEL_IDLE, SEL_WMARK
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CFG:    return SEL_CFG;
            OFF_STATUS: return SEL_STATUS;
            OFF_MSET:   return SEL_MSET;
            OFF_MCLR:   return SEL_MCLR;
            OFF_MASK:   return SEL_MASK;
            OFF_EN:     return SEL_EN;
            OFF_DELAY:  return SEL_DELAY;
            OFF_TXD:    return SEL_TXD;
            OFF_RXD:    return SEL_RXD;
            OFF_IDLE:   return SEL_IDLE;
            OFF_WMARK:  return SEL_WMARK;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(count)); // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0)); // R7

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] evt_set,
    input  logic [IRQ_W-1:0] level_in,
    input  logic             w1c_we,
    input  logic [IRQ_W-1:0] w1c_bits,
    input  logic             mask_set_we,
    input  logic             mask_clr_we,
    input  logic [IRQ_W-1:0] mask_bits,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] mask_q,
    output logic             irq
);

    logic [IRQ_W-1:0] evt_q;
    logic [IRQ_W-1:0] clr_vec;

    assign clr_vec = w1c_we ? w1c_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            mask_q <= '0;
        end else begin
            evt_q <= ((evt_q & ~clr_vec) | evt_set) & EVENT_BITS;
            if (mask_set_we)      mask_q <= mask_q | mask_bits;
            else if (mask_clr_we) mask_q <= mask_q & ~mask_bits;
        end
    end

    assign status = evt_q | (level_in & ~EVENT_BITS);
    assign irq    = |(status & mask_q);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        mask_set_we |=> ((mask_q & $past(mask_bits)) == $past(mask_bits))); // R3
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        (mask_clr_we && !mask_set_we) |=> ((mask_q & $past(mask_bits)) == '0)); // R3
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !w1c_we |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|(evt_set & EVENT_BITS)) |=>
            ((evt_q & $past(evt_set & EVENT_BITS)) == $past(evt_set & EVENT_BITS))); // R4
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R11

endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_regs_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int WM_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic              en_q,
    output logic [DATA_W-1:0] delay_q,
    output logic [IDLE_W-1:0] idle_q,
    output logic [WM_W-1:0]   wm_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            en_q    <= 1'b0;
            delay_q <= '0;
            idle_q  <= '0;
            wm_q    <= WM_W'(1);
        end else if (we) begin
            case (sel)
                SEL_CFG:   cfg_q   <= wdata;
                SEL_EN:    en_q    <= wdata[0];
                SEL_DELAY: delay_q <= wdata;
                SEL_IDLE:  idle_q  <= wdata[IDLE_W-1:0];
                SEL_WMARK: wm_q    <= wdata[WM_W-1:0];
                default:   ;
            endcase
        end
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(cfg_q) && $stable(en_q) && $stable(delay_q)
                 && $stable(idle_q) && $stable(wm_q))); // R2

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_regs_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int IDLE_W     = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int WM_W      = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [7:0]        eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_mode_fault,
    output logic [DATA_W-1:0] cfg_word,
    output logic              ctl_enable,
    output logic [DATA_W-1:0] delay_word,
    output logic [IDLE_W-1:0] idle_count,
    output logic              irq
);

    reg_sel_e          sel;
    logic [WM_W-1:0]   wm_q;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]        rx_head;
    logic              tx_push, rx_pop;
    logic              tx_low_now, tx_low_q;
    irq_vec_t          evt_set, level_in;
    logic [IRQ_W-1:0]  status, mask_q;

    assign sel     = decode_addr(bus_addr);
    assign tx_push = bus_we && (sel == SEL_TXD);
    assign rx_pop  = bus_re && (sel == SEL_RXD);

    spi_ctl_regs #(.IDLE_W(IDLE_W), .WM_W(WM_W)) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .sel     (sel),
        .wdata   (bus_wdata),
        .cfg_q   (cfg_word),
        .en_q    (ctl_enable),
        .delay_q (delay_word),
        .idle_q  (idle_count),
        .wm_q    (wm_q)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) tx_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_data (bus_wdata[7:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) rx_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign eng_tx_valid = !tx_empty;

    // Watermark edge: starts "already low" so reset raises nothing
    assign tx_low_now = (tx_count < wm_q);

    always_ff @(posedge clk) begin
        if (rst) tx_low_q <= 1'b1;
        else     tx_low_q <= tx_low_now;
    end

    always_comb begin
        evt_set            = '0;
        evt_set.rx_ovr     = eng_rx_push && rx_full;
        evt_set.mode_fault = eng_mode_fault;
        evt_set.tx_low     = tx_low_now && !tx_low_q;
        evt_set.tx_under   = eng_tx_pop && tx_empty;
        level_in           = '0;
        level_in.tx_full   = tx_full;
        level_in.rx_avail  = !rx_empty;
        level_in.rx_full   = rx_full;
    end

    spi_irq_unit irq_i (
        .clk         (clk),
        .rst         (rst),
        .evt_set     (evt_set),
        .level_in    (level_in),
        .w1c_we      (bus_we && (sel == SEL_STATUS)),
        .w1c_bits    (bus_wdata[IRQ_W-1:0]),
        .mask_set_we (bus_we && (sel == SEL_MSET)),
        .mask_clr_we (bus_we && (sel == SEL_MCLR)),
        .mask_bits   (bus_wdata[IRQ_W-1:0]),
        .status      (status),
        .mask_q      (mask_q),
        .irq         (irq)
    );

    always_comb begin
        case (sel)
            SEL_CFG:    bus_rdata = cfg_word;
            SEL_STATUS: bus_rdata = DATA_W'(status);
            SEL_MASK:   bus_rdata = DATA_W'(mask_q);
            SEL_EN:     bus_rdata = DATA_W'(ctl_enable);
            SEL_DELAY:  bus_rdata = delay_word;
            SEL_RXD:    bus_rdata = DATA_W'(rx_head);
            SEL_IDLE:   bus_rdata = DATA_W'(idle_count);
            SEL_WMARK:  bus_rdata = DATA_W'(wm_q);
            default:    bus_rdata = '0;
        endcase
    end

    AST_RX_ORDER: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_empty && !eng_rx_push) |=> (rx_count == $past(rx_count) - 1'b1)); // R7
    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !eng_tx_pop) |=> tx_full); // R6
    AST_OVR_LATCH: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && rx_full) |=> status[0]); // R10
    AST_MODF_LATCH: assert property (@(posedge clk) disable iff (rst)
        eng_mode_fault |=> status[1]); // R9

endmodule

// File: tb/spi_regfile_tb.sv
module spi_regfile_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  eng_tx_data, eng_rx_data = '0, idle_count;
    logic        eng_tx_valid, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic        eng_mode_fault = 1'b0, ctl_enable, irq;
    logic [31:0] cfg_word, delay_word;

    int total = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfile dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_data(eng_tx_data),
        .eng_tx_valid(eng_tx_valid), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_mode_fault(eng_mode_fault), .cfg_word(cfg_word),
        .ctl_enable(ctl_enable), .delay_word(delay_word), .idle_count(idle_count), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic eng_pop();
        @(negedge clk);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_data = b; eng_rx_push = 1'b1;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] m;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rchk("R1 cfg", 8'h00, 0);
        rchk("R1 enable", 8'h14, 0);
        rchk("R1 delay", 8'h18, 0);
        rchk("R1 idle", 8'h24, 0);
        rchk("R1 watermark", 8'h28, 1);
        rchk("R1 mask", 8'h10, 0);
        rchk("R1 status", 8'h04, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx valid", 32'(eng_tx_valid), 0);

        // R2 control registers and widths
        wr(8'h00, 32'hA5A5_1234); rchk("R2 cfg", 8'h00, 32'hA5A5_1234);
        chk("R2 cfg port", cfg_word, 32'hA5A5_1234);
        wr(8'h18, 32'hDEAD_BEEF); rchk("R2 delay", 8'h18, 32'hDEAD_BEEF);
        chk("R2 delay port", delay_word, 32'hDEAD_BEEF);
        wr(8'h24, 32'h0000_01FF); rchk("R2 idle", 8'h24, 32'hFF);
        chk("R2 idle port", 32'(idle_count), 32'hFF);
        wr(8'h14, 32'hFFFF_FFFF); rchk("R2 enable on", 8'h14, 1);
        chk("R2 enable port", 32'(ctl_enable), 1);
        wr(8'h14, 32'h0); rchk("R2 enable off", 8'h14, 0);
        wr(8'h28, 32'h0000_01FF); rchk("R2 watermark", 8'h28, 32'hFF);

        // R12 write-only and unmapped read zero
        rchk("R12 txd", 8'h1C, 0);
        rchk("R12 unmapped", 8'h2C, 0);
        rchk("R12 unmapped hi", 8'hFC, 0);

        // R3 mask set/clear sweep
        m = 0;
        for (int b = 0; b < 7; b++) begin
            wr(8'h08, 32'(1) << b);
            m |= 32'(1) << b;
            rchk("R3 set", 8'h10, m);
        end
        wr(8'h08, 0); rchk("R3 set zero", 8'h10, 32'h7F);
        wr(8'h0C, 0); rchk("R3 clr zero", 8'h10, 32'h7F);
        rchk("R3 set reg reads 0", 8'h08, 0);
        rchk("R3 clr reg reads 0", 8'h0C, 0);
        for (int b = 0; b < 7; b++) begin
            wr(8'h0C, 32'(1) << b);
            m &= ~(32'(1) << b);
            rchk("R3 clr", 8'h10, m);
        end
        wr(8'h08, 32'hFFFF_FFFF); rchk("R3 set all", 8'h10, 32'h7F);
        wr(8'h0C, 32'hFFFF_FFFF); rchk("R3 clr all", 8'h10, 0);

        // R6 TX fill, drop, drain; R8 watermark
        wr(8'h28, 4);
        for (int i = 0; i < 128; i++) wr(8'h1C, 32'((i * 7 + 3) & 8'hFF));
        rchk("R5 tx full", 8'h04, 32'h08);
        wr(8'h1C, 32'hEE);
        rchk("R5 tx full after drop", 8'h04, 32'h08);
        wr(8'h04, 32'h08);
        rchk("R5 w1c level kept", 8'h04, 32'h08);
        for (int i = 0; i < 128; i++) begin
            chk("R6 tx order", 32'(eng_tx_data), 32'((i * 7 + 3) & 8'hFF));
            chk("R6 tx valid", 32'(eng_tx_valid), 1);
            eng_pop();
            if (i == 123) rchk("R8 at watermark", 8'h04, 0);
            if (i == 124) rchk("R8 below watermark", 8'h04, 32'h04);
        end
        chk("R6 drop left empty", 32'(eng_tx_valid), 0);
        eng_pop();
        rchk("R10 tx underrun", 8'h04, 32'h44);
        wr(8'h04, 32'h44);
        rchk("R4 w1c clears", 8'h04, 0);

        // R7 RX fill, overrun, drain, empty read
        for (int i = 0; i < 128; i++) eng_push(8'(i) ^ 8'h5A);
        rchk("R5 rx full", 8'h04, 32'h30);
        eng_push(8'hC3);
        rchk("R10 rx overrun", 8'h04, 32'h31);
        wr(8'h04, 32'h31);
        rchk("R5 w1c leaves levels", 8'h04, 32'h30);
        for (int i = 0; i < 128; i++) rchk("R7 rx order", 8'h20, 32'(8'(i) ^ 8'h5A));
        rchk("R7 rx empty status", 8'h04, 0);
        rchk("R7 empty read", 8'h20, 0);
        rchk("R7 empty read status", 8'h04, 0);
        eng_push(8'h77);
        rchk("R7 pointers intact", 8'h20, 32'h77);

        // R9 mode fault, R11 irq
        @(negedge clk); eng_mode_fault = 1'b1;
        @(negedge clk); eng_mode_fault = 1'b0;
        rchk("R9 mode fault", 8'h04, 32'h02);
        chk("R11 masked off", 32'(irq), 0);
        wr(8'h08, 32'h02);
        chk("R11 irq on", 32'(irq), 1);
        wr(8'h0C, 32'h02);
        chk("R11 irq off by mask", 32'(irq), 0);
        wr(8'h04, 32'h02);
        rchk("R9 cleared", 8'h04, 0);

        // R4 set wins over clear
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h02; bus_we = 1'b1; eng_mode_fault = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; eng_mode_fault = 1'b0;
        rchk("R4 set wins", 8'h04, 32'h02);
        wr(8'h04, 32'h02);

        // R11 with a level source
        wr(8'h08, 32'h10);
        chk("R11 no source", 32'(irq), 0);
        eng_push(8'h11);
        chk("R11 rx level irq", 32'(irq), 1);
        rchk("R7 single byte", 8'h20, 32'h11);
        chk("R11 level gone", 32'(irq), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule